// File: doc/BRIEF.md
# Frame Phase Meter

This block measures where a recovered 8 kHz reference lands inside the local frame. A bit-clock counter restarts on every local frame pulse. The reference passes through a short synchronizer and an edge detector. On each detected rising edge of the reference, the counter value is captured.

The 8-bit capture is reported in two parts. The upper five bits give the channel (0 to 31). The lower three bits give the bit position within that channel.

A ninth bit inverts whenever consecutive captures cross the frame boundary, in either direction. Software that watches this bit can follow phase drift of more than one frame, for example while it steers a frequency correction loop. The control and status pins are plain levels; the block has no streaming interface.

Top module: `frame_phase_meter`

## Requirements
- R1: While reset is asserted, the channel count, the bit count and the wrap bit all read 0.
- R2: The phase counter reads 0 in the cycle after a clock edge that samples the frame pulse high. It then advances by one per bit clock and rolls over from 255 to 0. A capture stores the counter value as an 8-bit phase: channel count = phase[7:3], bit count = phase[2:0].
- R3: A capture happens exactly SYNC_STAGES+1 clock edges after the first edge that samples the reference high following a low sample (3 edges with the default of 2 stages). The outputs change only on a capture.
- R4: On a capture, the wrap bit inverts when the previous phase is at least 192 and the new phase is below 64 (an increasing reading passing channel 31, bit 7). The limits come from WRAP_WINDOW = 64.
- R5: On a capture, the wrap bit inverts when the previous phase is below 64 and the new phase is at least 192 (a decreasing reading passing below channel 0, bit 0).
- R6: A capture that meets neither the R4 nor the R5 condition leaves the wrap bit unchanged.
- R7: The first capture after reset never inverts the wrap bit, whatever its value.
- R8: A reference held high or held low produces no capture. The outputs keep their last value.
- R9: A frame pulse arriving at any point in the frame restarts the counter at 0, so later captures are measured from that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | Local frame start, sampled on the bit clock |
| ref_8k | input | 1 | Recovered 8 kHz reference; asynchronous to the bit clock |
| chan_cnt | output | 5 | Channel number of the last capture |
| bit_cnt | output | 3 | Bit position within the channel of the last capture |
| frame_wrap | output | 1 | Inverts each time the reading crosses the frame boundary |

## Verification
A frame pulse changes the counter on the next edge. A reference rise shows up on chan_cnt, bit_cnt and frame_wrap SYNC_STAGES+1 edges after it is first sampled. The bench model pushes every sampled reference value through a queue of that length and updates its expected outputs in the same edge as the design. Outputs are compared at each falling edge, so every result is read half a cycle after the edge that produced it. The directed checks wait a computed number of falling edges: SYNC_STAGES+1 after raising the reference, and SYNC_STAGES+2 for a snapshot taken once a capture has settled.

// File: rtl/frame_phase_pkg.sv
package frame_phase_pkg;
  localparam int DEF_CHAN_W      = 5;
  localparam int DEF_BIT_W       = 3;
  localparam int DEF_SYNC_STAGES = 2;
  localparam int DEF_WRAP_WINDOW = 64;

  typedef enum logic [1:0] {
    WRAP_NONE = 2'd0,
    WRAP_UP   = 2'd1,
    WRAP_DOWN = 2'd2
  } wrap_dir_e;
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              hist_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~hist_q;
endmodule

// File: rtl/bit_phase_counter.sv
module bit_phase_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= '0;
    else              count <= count + 1'b1;
  end
endmodule

// File: rtl/phase_wrap_track.sv
module phase_wrap_track
  import frame_phase_pkg::*;
#(
  parameter int W      = 8,
  parameter int WINDOW = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] sample,
  output logic [W-1:0] phase,
  output logic         wrap_bit,
  output logic         have_prev
);
  localparam int          HIGH_INT = (1 << W) - WINDOW;
  localparam logic [W-1:0] LOW_LIM  = WINDOW[W-1:0];
  localparam logic [W-1:0] HIGH_LIM = HIGH_INT[W-1:0];

  wrap_dir_e dir;

  always_comb begin
    dir = WRAP_NONE;
    if (have_prev) begin
      if (phase >= HIGH_LIM && sample < LOW_LIM)      dir = WRAP_UP;
      else if (phase < LOW_LIM && sample >= HIGH_LIM) dir = WRAP_DOWN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      wrap_bit  <= 1'b0;
      have_prev <= 1'b0;
    end else if (capture) begin
      phase     <= sample;
      have_prev <= 1'b1;
      if (dir != WRAP_NONE) wrap_bit <= ~wrap_bit;
    end
  end
endmodule

// File: rtl/frame_phase_meter.sv
module frame_phase_meter
  import frame_phase_pkg::*;
#(
  parameter int CHAN_W      = DEF_CHAN_W,
  parameter int BIT_W       = DEF_BIT_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int WRAP_WINDOW = DEF_WRAP_WINDOW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_pulse,
  input  logic              ref_8k,
  output logic [CHAN_W-1:0] chan_cnt,
  output logic [BIT_W-1:0]  bit_cnt,
  output logic              frame_wrap
);
  localparam int PHASE_W = CHAN_W + BIT_W;

  logic               ref_rise;
  logic               have_prev;
  logic [PHASE_W-1:0] bit_clk_cnt;
  logic [PHASE_W-1:0] phase_q;

  ref_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ref_8k),
    .rise     (ref_rise)
  );

  bit_phase_counter #(.W(PHASE_W)) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (frame_pulse),
    .count   (bit_clk_cnt)
  );

  phase_wrap_track #(.W(PHASE_W), .WINDOW(WRAP_WINDOW)) wrap_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (ref_rise),
    .sample    (bit_clk_cnt),
    .phase     (phase_q),
    .wrap_bit  (frame_wrap),
    .have_prev (have_prev)
  );

  assign chan_cnt = phase_q[PHASE_W-1:BIT_W];
  assign bit_cnt  = phase_q[BIT_W-1:0];
endmodule

// File: rtl/frame_phase_meter_chk.sv
module frame_phase_meter_chk #(
  parameter int PHASE_W     = 8,
  parameter int WRAP_WINDOW = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_pulse,
  input logic               cap_en,
  input logic               have_prev,
  input logic [PHASE_W-1:0] count,
  input logic [PHASE_W-1:0] phase_out,
  input logic               frame_wrap
);
  localparam int HI = (1 << PHASE_W) - WRAP_WINDOW;
  localparam int LO = WRAP_WINDOW;

  logic up_c, dn_c;
  assign up_c = have_prev && (int'(phase_out) >= HI) && (int'(count) < LO);
  assign dn_c = have_prev && (int'(phase_out) < LO) && (int'(count) >= HI);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (phase_out == '0 && !frame_wrap));

  assert_capture_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> phase_out == $past(count));

  assert_hold_no_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ($stable(phase_out) && $stable(frame_wrap)));

  assert_wrap_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && up_c) |=> frame_wrap != $past(frame_wrap));

  assert_wrap_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && dn_c) |=> frame_wrap != $past(frame_wrap));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !up_c && !dn_c) |=> $stable(frame_wrap));

  assert_first_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !have_prev) |=> ($stable(frame_wrap) && have_prev));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> count == '0);
endmodule

bind frame_phase_meter frame_phase_meter_chk #(
  .PHASE_W(PHASE_W), .WRAP_WINDOW(WRAP_WINDOW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_pulse (frame_pulse),
  .cap_en      (ref_rise),
  .have_prev   (have_prev),
  .count       (bit_clk_cnt),
  .phase_out   ({chan_cnt, bit_cnt}),
  .frame_wrap  (frame_wrap)
);

// File: tb/frame_phase_meter_tb_top.sv
`timescale 1ns/1ps
module frame_phase_meter_tb_top;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_pulse = 1'b0;
  logic       ref_8k = 1'b0;
  logic [4:0] chan_cnt;
  logic [2:0] bit_cnt;
  logic       frame_wrap;

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  bit fp_en = 1'b0;
  bit done = 1'b0;

  int m_cnt = 0, m_phase = 0, m_wrap = 0, m_have = 0;
  int q[$];
  int wrap_changes = 0;

  always #4 clk = ~clk;

  frame_phase_meter dut_i (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ref_8k(ref_8k),
    .chan_cnt(chan_cnt), .bit_cnt(bit_cnt), .frame_wrap(frame_wrap)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  initial begin
    for (int i = 0; i <= S; i++) q.push_back(0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_phase = 0; m_wrap = 0; m_have = 0;
      for (int i = 0; i <= S; i++) q[i] = 0;
    end else begin
      if (q[S-1] == 1 && q[S] == 0) begin
        if (m_have == 1 &&
            ((m_phase >= 192 && m_cnt < 64) || (m_phase < 64 && m_cnt >= 192))) begin
          m_wrap = 1 - m_wrap;
          wrap_changes++;
        end
        m_phase = m_cnt;
        m_have = 1;
      end
      m_cnt = frame_pulse ? 0 : (m_cnt + 1) % 256;
      q.push_front(int'(ref_8k));
      void'(q.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({tag, " chan"}, int'(chan_cnt), m_phase / 8);
      check({tag, " bit"}, int'(bit_cnt), m_phase % 8);
      check({tag, " wrap"}, int'(frame_wrap), m_wrap);
    end
  end

  // frame pulse generator
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k = (k + 1) % 256;
      if (fp_en) frame_pulse = (k == 0);
    end
  end

  task automatic ref_train(input int period, input int n);
    for (int i = 0; i < n; i++) begin
      ref_8k = 1'b1;
      repeat (period / 2) @(negedge clk);
      ref_8k = 1'b0;
      repeat (period - period / 2) @(negedge clk);
    end
  endtask

  initial begin
    int snap, w0;
    repeat (5) @(negedge clk);
    check("R1 chan", int'(chan_cnt), 0);
    check("R1 bit", int'(bit_cnt), 0);
    check("R1 wrap", int'(frame_wrap), 0);
    rst_n = 1'b1;
    fp_en = 1'b1;

    // R7: first capture lands high in the frame, no toggle
    tag = "R7";
    while (m_cnt != 200) @(negedge clk);
    ref_8k = 1'b1;
    repeat (S + 2) @(negedge clk);
    check("R7 first capture wrap", int'(frame_wrap), 0);
    check("R7 first capture chan", int'(chan_cnt), (200 + S) / 8);
    ref_8k = 1'b0;
    repeat (100) @(negedge clk);

    tag = "R2"; ref_train(256, 4);
    tag = "R3"; ref_train(256, 2);

    tag = "R4"; w0 = wrap_changes;
    ref_train(304, 12);
    check("R4 up wraps seen", int'(wrap_changes > w0), 1);

    tag = "R5"; w0 = wrap_changes;
    ref_train(208, 12);
    check("R5 down wraps seen", int'(wrap_changes > w0), 1);

    tag = "R6"; ref_train(356, 6);

    // R8: reference held high, no capture
    tag = "R8";
    ref_8k = 1'b1;
    repeat (S + 2) @(negedge clk);
    snap = {26'd0, chan_cnt, bit_cnt};
    w0 = int'(frame_wrap);
    repeat (700) @(negedge clk);
    check("R8 held high phase", int'({chan_cnt, bit_cnt}), snap);
    check("R8 held high wrap", int'(frame_wrap), w0);
    ref_8k = 1'b0;
    repeat (600) @(negedge clk);
    check("R8 held low phase", int'({chan_cnt, bit_cnt}), snap);

    // R9: extra frame pulse mid-frame
    tag = "R9";
    fp_en = 1'b0;
    frame_pulse = 1'b0;
    repeat (37) @(negedge clk);
    frame_pulse = 1'b1;
    @(negedge clk);
    frame_pulse = 1'b0;
    repeat (9) @(negedge clk);
    ref_8k = 1'b1;
    repeat (S + 1) @(negedge clk);
    check("R9 restart phase", int'({chan_cnt, bit_cnt}), 9 + S);
    ref_8k = 1'b0;
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule